// File: doc/BRIEF.md
# Memory Port Data/Address Multiplexor

This block joins one word-wide memory port to several requesters: a processor and a parameter-set number of data channels. Words coming back from memory are captured onto one shared read bus. A valid strobe then goes to the requester that holds the grant for that cycle. Outgoing write words from all requesters are merged by a gated OR bus that has no path in common with the read bus. Each requester's word is masked by its grant bit, so only the owner of the cycle reaches memory.

A separate address selector drives the memory address. The source is picked by a look-ahead control input, not by a fixed priority. It can pick the processor's address, one channel's address chosen by an index, the address field of the last word read, or zero. The same selected address is also fanned out to every channel's location-counter load input.

The grant vector is one-hot or all zeros. Bit 0 belongs to the processor and bit k (k ≥ 1) belongs to channel k-1. Words are 36 bits wide and addresses are 15 bits wide. The channel count is a parameter from 1 to 8.

Top module: `mem_port_mux`

## Requirements
- R1: While reset is asserted and after it is released with no read, `rdStrobe` is all zeros and `rdBus` is all zeros.
- R2: When `memRdValid` is 1 at a rising clock edge, `rdBus` holds `memRdData` and `rdStrobe` equals `grant` from the next cycle, for exactly one cycle per valid. Grant bit 0 is the processor and bit k is channel k-1.
- R3: When `memRdValid` is 0 at an edge, `rdStrobe` is all zeros in the next cycle and `rdBus` keeps its previous value.
- R4: With an all-zero `grant`, `memWrData` is zero. A read with `memRdValid` 1 and an all-zero grant raises no strobe bit, but `rdBus` still captures the word.
- R5: `memWrData` equals the write word of the single granted requester. Data from requesters that are not granted has no effect on it.
- R6: With `addrSrc` = 2'b00, `memAddr` equals `cpuAddr`.
- R7: With `addrSrc` = 2'b01, `memAddr` equals channel `addrChan`'s address, which is slice `addrChan` of `chanAddr` (15 bits per channel, channel 0 in the lowest bits). An index of `NUM_CHAN` or more gives zero.
- R8: With `addrSrc` = 2'b10, `memAddr` equals the address field of the word on `rdBus`. This field is word bits 21 to 35, counting bit 0 as the leftmost (most significant) bit, so it is `rdBus[14:0]`.
- R9: With `addrSrc` = 2'b11, `memAddr` is zero.
- R10: Every 15-bit slice of `chanLocAddr` equals `memAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| grant | input | NUM_CHAN+1 | One-hot cycle owner (bit 0 processor), or zero |
| memRdValid | input | 1 | Memory read word valid |
| memRdData | input | 36 | Word read from memory |
| rdBus | output | 36 | Shared registered read bus |
| rdStrobe | output | NUM_CHAN+1 | Per-requester read valid, one cycle after memRdValid |
| cpuWrData | input | 36 | Processor write word |
| chanWrData | input | 36*NUM_CHAN | Channel write words, channel 0 lowest |
| memWrData | output | 36 | Merged write word to memory |
| addrSrc | input | 2 | Look-ahead address source select |
| addrChan | input | $clog2(NUM_CHAN+1) | Channel index for channel address source |
| cpuAddr | input | 15 | Processor address |
| chanAddr | input | 15*NUM_CHAN | Channel addresses, channel 0 lowest |
| memAddr | output | 15 | Selected memory address |
| chanLocAddr | output | 15*NUM_CHAN | Selected address copied to each channel's location-counter load |

## Verification
The assertions assume that `grant` is one-hot or all zeros in every cycle out of reset. The strobe-timing properties also rely on `grant` being sampled in the same cycle as `memRdValid`. The stimulus keeps within this by setting `grant` only to single-bit patterns or zero, and it changes all inputs on falling edges. Write and address checks are made with combinational settling before any compare. Read results go through a queue that the bench fills one entry per driven cycle.

// File: rtl/mem_port_mux_pkg.sv
package mem_port_mux_pkg;

  localparam int MAX_REQ = 9;

  typedef enum logic [1:0] {
    ADDR_CPU   = 2'b00,
    ADDR_CHAN  = 2'b01,
    ADDR_FIELD = 2'b10,
    ADDR_NONE  = 2'b11
  } addr_src_e;

  typedef struct packed {
    logic                 rdLoad;
    addr_src_e            addrMode;
    logic [MAX_REQ-1:0]   wrGate;
  } mux_ctl_t;

endpackage

// File: rtl/mem_port_mux_ctrl.sv
module mem_port_mux_ctrl
  import mem_port_mux_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  localparam int NUM_REQ = NUM_CHAN + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] grant,
  input  logic               memRdValid,
  input  logic [1:0]         addrSrc,
  output mux_ctl_t           ctl,
  output logic [NUM_REQ-1:0] rdStrobe
);

  always_comb begin
    ctl                       = '0;
    ctl.rdLoad                = memRdValid;
    ctl.addrMode              = addr_src_e'(addrSrc);
    ctl.wrGate[NUM_REQ-1:0]   = grant;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdStrobe <= '0;
    else if (memRdValid) rdStrobe <= grant;
    else                 rdStrobe <= '0;
  end

  // Input assumption: at most one owner per cycle (R2)
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_strobe_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |=> rdStrobe == $past(grant));

  p_strobe_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memRdValid |=> rdStrobe == '0);

endmodule

// File: rtl/mem_port_mux_dp.sv
module mem_port_mux_dp
  import mem_port_mux_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int WORD_W   = 36,
  parameter int ADDR_W   = 15,
  localparam int NUM_REQ  = NUM_CHAN + 1,
  localparam int CH_IDX_W = $clog2(NUM_CHAN + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  mux_ctl_t                   ctl,
  input  logic [WORD_W-1:0]          memRdData,
  input  logic [WORD_W-1:0]          cpuWrData,
  input  logic [WORD_W*NUM_CHAN-1:0] chanWrData,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [ADDR_W*NUM_CHAN-1:0] chanAddr,
  input  logic [CH_IDX_W-1:0]        addrChan,
  output logic [WORD_W-1:0]          rdBus,
  output logic [WORD_W-1:0]          memWrData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [ADDR_W*NUM_CHAN-1:0] chanLocAddr
);

  // Read bus register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdBus <= '0;
    else if (ctl.rdLoad) rdBus <= memRdData;
  end

  // Gated OR write bus, independent of the read path
  logic [WORD_W-1:0] gatedWr [NUM_REQ];
  assign gatedWr[0] = cpuWrData & {WORD_W{ctl.wrGate[0]}};

  for (genvar k = 1; k < NUM_REQ; k++) begin : g_chanGate
    assign gatedWr[k] = chanWrData[(k-1)*WORD_W +: WORD_W] & {WORD_W{ctl.wrGate[k]}};
  end

  always_comb begin
    memWrData = '0;
    for (int k = 0; k < NUM_REQ; k++) memWrData = memWrData | gatedWr[k];
  end

  logic unusedGate;
  assign unusedGate = ^ctl.wrGate;

  // Address selector
  logic [ADDR_W-1:0] chanPick;
  always_comb begin
    chanPick = '0;
    for (int k = 0; k < NUM_CHAN; k++)
      if (int'(addrChan) == k) chanPick = chanAddr[k*ADDR_W +: ADDR_W];
  end

  always_comb begin
    unique case (ctl.addrMode)
      ADDR_CPU:   memAddr = cpuAddr;
      ADDR_CHAN:  memAddr = chanPick;
      ADDR_FIELD: memAddr = rdBus[ADDR_W-1:0];
      default:    memAddr = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_CHAN; k++) begin : g_locFan
    assign chanLocAddr[k*ADDR_W +: ADDR_W] = memAddr;
  end

  p_rdbus_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdLoad |=> rdBus == $past(memRdData));

  p_rdbus_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdLoad |=> $stable(rdBus));

endmodule

// File: rtl/mem_port_mux.sv
module mem_port_mux
  import mem_port_mux_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int WORD_W   = 36,
  parameter int ADDR_W   = 15,
  localparam int NUM_REQ  = NUM_CHAN + 1,
  localparam int CH_IDX_W = $clog2(NUM_CHAN + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REQ-1:0]         grant,
  input  logic                       memRdValid,
  input  logic [WORD_W-1:0]          memRdData,
  output logic [WORD_W-1:0]          rdBus,
  output logic [NUM_REQ-1:0]         rdStrobe,
  input  logic [WORD_W-1:0]          cpuWrData,
  input  logic [WORD_W*NUM_CHAN-1:0] chanWrData,
  output logic [WORD_W-1:0]          memWrData,
  input  logic [1:0]                 addrSrc,
  input  logic [CH_IDX_W-1:0]        addrChan,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [ADDR_W*NUM_CHAN-1:0] chanAddr,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [ADDR_W*NUM_CHAN-1:0] chanLocAddr
);

  mux_ctl_t ctl;

  mem_port_mux_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .clk(clk), .rstN(rstN), .grant(grant), .memRdValid(memRdValid),
    .addrSrc(addrSrc), .ctl(ctl), .rdStrobe(rdStrobe)
  );

  mem_port_mux_dp #(.NUM_CHAN(NUM_CHAN), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData),
    .cpuWrData(cpuWrData), .chanWrData(chanWrData), .cpuAddr(cpuAddr),
    .chanAddr(chanAddr), .addrChan(addrChan), .rdBus(rdBus),
    .memWrData(memWrData), .memAddr(memAddr), .chanLocAddr(chanLocAddr)
  );

  p_wr_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0) |-> (memWrData == '0));

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdStrobe));

endmodule

// File: tb/mem_port_mux_test.sv
`timescale 1ns/1ps
module mem_port_mux_test;
  localparam int NC = 4;
  localparam int W  = 36;
  localparam int A  = 15;
  localparam int NR = NC + 1;
  localparam int CI = $clog2(NC + 1);

  logic clk = 1'b0;
  logic rstN;
  logic [NR-1:0]   grant;
  logic            memRdValid;
  logic [W-1:0]    memRdData, rdBus, cpuWrData, memWrData;
  logic [NR-1:0]   rdStrobe;
  logic [W*NC-1:0] chanWrData;
  logic [1:0]      addrSrc;
  logic [CI-1:0]   addrChan;
  logic [A-1:0]    cpuAddr, memAddr;
  logic [A*NC-1:0] chanAddr, chanLocAddr;

  always #2.5 clk = ~clk;

  mem_port_mux #(.NUM_CHAN(NC)) uut (
    .clk(clk), .rstN(rstN), .grant(grant), .memRdValid(memRdValid),
    .memRdData(memRdData), .rdBus(rdBus), .rdStrobe(rdStrobe),
    .cpuWrData(cpuWrData), .chanWrData(chanWrData), .memWrData(memWrData),
    .addrSrc(addrSrc), .addrChan(addrChan), .cpuAddr(cpuAddr),
    .chanAddr(chanAddr), .memAddr(memAddr), .chanLocAddr(chanLocAddr)
  );

  typedef struct {
    logic [NR-1:0] stb;
    logic [W-1:0]  data;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [W-1:0] lastWord = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rdCycle(input logic v, input logic [NR-1:0] g, input logic [W-1:0] d,
                         input string tag);
    exp_t e;
    @(negedge clk);
    memRdValid = v;
    grant      = g;
    memRdData  = d;
    if (v) lastWord = d;
    e.stb  = v ? g : '0;
    e.data = lastWord;
    e.tag  = tag;
    sbq.push_back(e);
  endtask

  // Monitor: pops one expectation per cycle after the registering edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN === 1'b1 && sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " strobe"}, 64'(rdStrobe), 64'(e.stb));
        check({e.tag, " rdBus"},  64'(rdBus),    64'(e.data));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; grant = '0; memRdValid = 1'b0; memRdData = '0;
    cpuWrData = '0; chanWrData = '0; addrSrc = 2'b00; addrChan = '0;
    cpuAddr = '0; chanAddr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset strobe", 64'(rdStrobe), 64'd0);
    check("R1 reset rdBus",  64'(rdBus),    64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset strobe", 64'(rdStrobe), 64'd0);
    check("R1 post-reset rdBus",  64'(rdBus),    64'd0);

    // Reads: R2, R3, R4
    rdCycle(1'b1, 5'b00001, 36'h1_2345_6789, "R2 cpu");
    rdCycle(1'b1, 5'b00100, 36'hA_BCDE_F012, "R2 chan1");
    rdCycle(1'b1, 5'b10000, 36'hF_0F0F_0F0F, "R2 chan3");
    rdCycle(1'b0, 5'b00010, 36'h0_DEAD_BEEF, "R3 idle");
    rdCycle(1'b0, 5'b00001, 36'h5_5555_5555, "R3 idle2");
    rdCycle(1'b1, 5'b00000, 36'h3_0000_7ABC, "R4 nogrant");
    rdCycle(1'b1, 5'b01000, 36'h8_0000_1111, "R2 chan2");
    rdCycle(1'b0, 5'b00000, 36'h0, "R3 tail");
    repeat (2) @(negedge clk);

    // Writes: R5, R4
    cpuWrData = 36'h0_0000_00C5;
    for (int k = 0; k < NC; k++)
      chanWrData[k*W +: W] = 36'h1_0000_0000 * (k + 1) + 36'(k * 7 + 3);
    for (int g = 0; g < NR; g++) begin
      logic [W-1:0] expW;
      grant = NR'(1) << g;
      expW = (g == 0) ? cpuWrData : chanWrData[(g-1)*W +: W];
      #1 check("R5 write merge", 64'(memWrData), 64'(expW));
    end
    grant = '0;
    #1 check("R4 write zero", 64'(memWrData), 64'd0);

    // Addresses: R6..R10
    cpuAddr = 15'h1234;
    for (int k = 0; k < NC; k++) chanAddr[k*A +: A] = 15'(16'h0101 * (k + 1) + 16'h4000);
    addrSrc = 2'b00;
    #1 check("R6 cpu addr", 64'(memAddr), 64'(cpuAddr));
    for (int k = 0; k < NC; k++) begin
      addrSrc = 2'b01;
      addrChan = CI'(k);
      #1 check("R7 chan addr", 64'(memAddr), 64'(chanAddr[k*A +: A]));
    end
    addrChan = CI'(NC + 1);
    #1 check("R7 out of range", 64'(memAddr), 64'd0);
    addrSrc = 2'b10;
    #1 check("R8 field addr", 64'(memAddr), 64'(lastWord[A-1:0]));
    for (int k = 0; k < NC; k++)
      check("R10 loc fan", 64'(chanLocAddr[k*A +: A]), 64'(lastWord[A-1:0]));
    addrSrc = 2'b11;
    #1 check("R9 none addr", 64'(memAddr), 64'd0);
    addrSrc = 2'b00;
    #1 check("R10 loc fan cpu", 64'(chanLocAddr[(NC-1)*A +: A]), 64'(cpuAddr));

    // Field follows a fresh read
    rdCycle(1'b1, 5'b00010, 36'hC_0000_5A5A, "R2 chan0");
    rdCycle(1'b0, 5'b00000, 36'h0, "R3 after");
    repeat (2) @(negedge clk);
    addrSrc = 2'b10;
    #1 check("R8 field after read", 64'(memAddr), 64'h5A5A);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule